// File: doc/BRIEF.md
# Load/Store Port Handshake Monitor

This block watches one load/store request port between a compute unit and a memory buffer. It never drives the port. It follows each transaction from the moment a load or store request appears until busy falls, and it flags any step that breaks the handshake. The handshake does not allow fire-and-forget use: the buffer has to hold busy for the whole access, and busy may fall only in the cycle that the rules allow for how the access ended. Those cycles differ for an exception, a load and a store.

On the first broken rule the monitor raises a sticky error flag and keeps a rule code. The code holds until software clears it. The monitor also gives a one-cycle completion pulse for every load or store that ends correctly, so a scoreboard can count finished operations. The monitor checks only ordering and pulse widths. It does not check data values, exception kinds or arbitration between ports.

Top module: `ldst_port_monitor`

## Requirements
- R1: After reset, err_code_o is 0, err_o is 0 and txn_done_o is 0. In any cycle where abort_i is high, no rule is flagged and the monitor returns to idle, so a later address accept with no open transaction counts as code 6.
- R2: ld_req_i and st_req_i both high in the same cycle is rule code 1.
- R3: A new request (the combined request ld_req_i|st_req_i rising from 0 to 1) in a cycle where busy_i is high is rule code 2.
- R4: busy_i must be high in the cycle after a new request that opens a transaction. Otherwise it is rule code 3.
- R5: Once addr_vld_i is seen high during an open transaction with busy high, addr_vld_i must stay high and addr_i must keep the captured value while busy stays high. Otherwise it is rule code 4.
- R6: addr_ack_i, addr_exc_i, ld_vld_i or st_vld_i high for two cycles in a row is rule code 5.
- R7: addr_ack_i or addr_exc_i outside an open transaction, or a second accept/exception in one transaction (this includes an exception after an accept), is rule code 6.
- R8: addr_exc_i with busy_i still high is rule code 7. An exception with busy low ends the transaction and gives no completion pulse.
- R9: ld_vld_i outside an accepted load transaction is rule code 8. ld_vld_i with busy_i high is rule code 9.
- R10: st_vld_i outside an accepted store transaction is rule code 10. busy_i still high in the cycle after a valid st_vld_i is rule code 11.
- R11: busy_i falling during an open transaction with no exception and no load data in that cycle is rule code 12.
- R12: err_code_o is loaded one cycle after the first violating cycle. It takes the lowest code flagged in that cycle and then holds until clr_err_i, which wins over any new violation. err_o is high exactly when err_code_o is non-zero.
- R13: txn_done_o is high, in the same cycle, when busy falls with a valid load data pulse, or when busy falls in the cycle after a valid store data pulse, provided that no rule is flagged in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort_i | input | 1 | Returns the monitor to idle and suppresses checks for this cycle |
| clr_err_i | input | 1 | Synchronous clear of the error code |
| ld_req_i | input | 1 | Load request from the compute unit |
| st_req_i | input | 1 | Store request from the compute unit |
| busy_i | input | 1 | Busy from the buffer |
| addr_vld_i | input | 1 | Address valid from the compute unit |
| addr_i | input | AW | Access address |
| addr_ack_i | input | 1 | Address accept pulse from the buffer |
| addr_exc_i | input | 1 | Address exception pulse from the buffer |
| ld_vld_i | input | 1 | Load data valid pulse from the buffer |
| st_vld_i | input | 1 | Store data valid pulse from the compute unit |
| err_o | output | 1 | Sticky error flag |
| err_code_o | output | 4 | First violated rule code (0 = none) |
| txn_done_o | output | 1 | Completion pulse for a correct load or store |

## Verification
The hardest case to reach is a store that has been accepted and sent its data while busy stays high one cycle too long. Any earlier slip in the store sequence would trip a lower code first and hide the late busy. The stimulus therefore drives a correct store step by step up to its data pulse and then holds busy for one extra cycle. Tie-breaking is reached the same way: one scripted cycle breaks two rules at once, and a behavioural model in the bench predicts the code and the completion pulse on every cycle.

// File: rtl/ldst_mon_pkg.sv
package ldst_mon_pkg;
  localparam int RULE_N = 12;
  localparam int CODE_W = 4;

  // rule codes, lowest wins when several fire in one cycle
  localparam int HIT_BOTH      = 1;
  localparam int HIT_REQ_BUSY  = 2;
  localparam int HIT_NO_RISE   = 3;
  localparam int HIT_ADDR_MOVE = 4;
  localparam int HIT_WIDTH     = 5;
  localparam int HIT_RESP      = 6;
  localparam int HIT_EXC_BUSY  = 7;
  localparam int HIT_LD_STRAY  = 8;
  localparam int HIT_LD_BUSY   = 9;
  localparam int HIT_ST_STRAY  = 10;
  localparam int HIT_ST_HOLD   = 11;
  localparam int HIT_FALL      = 12;

  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_OPEN, PH_SEND} phase_e;

  function automatic logic [CODE_W-1:0] first_rule(input logic [RULE_N:1] hits);
    logic [CODE_W-1:0] code;
    code = '0;
    for (int i = RULE_N; i >= 1; i--) begin
      if (hits[i]) code = CODE_W'(i);
    end
    return code;
  endfunction
endpackage

// File: rtl/ldst_mon_pulse.sv
module ldst_mon_pulse #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic         wide_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] wide_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign wide_bits[g] = sig_i[g] & prev_q[g];
  end

  assign wide_o = |wide_bits;
endmodule

// File: rtl/ldst_mon_addr.sv
module ldst_mon_addr #(
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          track_i,
  input  logic          vld_i,
  input  logic [AW-1:0] addr_i,
  output logic          move_o
);
  logic          lock_q;
  logic [AW-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      held_q <= '0;
    end else begin
      lock_q <= track_i & (lock_q | vld_i);
      if (track_i & vld_i & ~lock_q) held_q <= addr_i;
    end
  end

  assign move_o = track_i & lock_q & (~vld_i | (addr_i != held_q));

  // R5
  addr_lock_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> $past(track_i));
endmodule

// File: rtl/ldst_mon_seq.sv
module ldst_mon_seq
  import ldst_mon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_i,
  input  logic              ld_req_i,
  input  logic              st_req_i,
  input  logic              busy_i,
  input  logic              ack_i,
  input  logic              exc_i,
  input  logic              ld_vld_i,
  input  logic              st_vld_i,
  input  logic              move_i,
  input  logic              wide_i,
  output logic              track_o,
  output logic [RULE_N:1]   hit_o,
  output logic              done_o
);
  phase_e ph_q, ph_d;
  logic   load_q, load_d, acked_q, acked_d, ans_q, ans_d, req_q;

  logic any_req, new_req, act, ld_ok, st_ok, done_raw;

  assign any_req = ld_req_i | st_req_i;
  assign new_req = any_req & ~req_q;
  assign act     = (ph_q == PH_WAIT) | (ph_q == PH_OPEN);
  assign ld_ok   = act & load_q & acked_q;
  assign st_ok   = act & ~load_q & acked_q;
  assign track_o = act & busy_i & ~abort_i;

  always_comb begin
    hit_o = '0;
    hit_o[HIT_BOTH]      = ld_req_i & st_req_i;
    hit_o[HIT_REQ_BUSY]  = new_req & busy_i;
    hit_o[HIT_NO_RISE]   = (ph_q == PH_WAIT) & ~busy_i;
    hit_o[HIT_ADDR_MOVE] = move_i;
    hit_o[HIT_WIDTH]     = wide_i;
    hit_o[HIT_RESP]      = (ack_i | exc_i) & (~act | ans_q);
    hit_o[HIT_EXC_BUSY]  = exc_i & busy_i & act;
    hit_o[HIT_LD_STRAY]  = ld_vld_i & ~ld_ok;
    hit_o[HIT_LD_BUSY]   = ld_vld_i & busy_i & act;
    hit_o[HIT_ST_STRAY]  = st_vld_i & ~st_ok;
    hit_o[HIT_ST_HOLD]   = (ph_q == PH_SEND) & busy_i;
    hit_o[HIT_FALL]      = (ph_q == PH_OPEN) & ~busy_i & ~exc_i & ~ld_vld_i;
    if (abort_i) hit_o = '0;
  end

  assign done_raw = ((ph_q == PH_OPEN) & ~busy_i & ld_vld_i & ld_ok)
                  | ((ph_q == PH_SEND) & ~busy_i);
  assign done_o   = done_raw & ~abort_i & ~(|hit_o);

  always_comb begin
    ph_d    = ph_q;
    load_d  = load_q;
    acked_d = acked_q;
    ans_d   = ans_q;
    unique case (ph_q)
      PH_IDLE: if (new_req & ~(ld_req_i & st_req_i)) begin
        ph_d    = PH_WAIT;
        load_d  = ld_req_i;
        acked_d = 1'b0;
        ans_d   = 1'b0;
      end
      PH_WAIT, PH_OPEN: begin
        if (!busy_i) ph_d = PH_IDLE;
        else begin
          acked_d = acked_q | ack_i;
          ans_d   = ans_q | ack_i | exc_i;
          ph_d    = (st_vld_i & st_ok) ? PH_SEND : PH_OPEN;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
    if (abort_i) ph_d = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      load_q  <= 1'b0;
      acked_q <= 1'b0;
      ans_q   <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      load_q  <= load_d;
      acked_q <= acked_d;
      ans_q   <= ans_d;
      req_q   <= any_req;
    end
  end

  // R10
  send_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SEND) |-> $past(st_vld_i));
  // R13
  done_busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_i);
  // R13
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/ldst_mon_errlog.sv
module ldst_mon_errlog
  import ldst_mon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic [RULE_N:1]   hit_i,
  output logic [CODE_W-1:0] code_o,
  output logic              err_o
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          code_q <= '0;
    else if (clr_i)                      code_q <= '0;
    else if ((code_q == '0) && |hit_i)   code_q <= first_rule(hit_i);
  end

  assign code_o = code_q;
  assign err_o  = (code_q != '0);

  // R12
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != '0 && !clr_i) |=> $stable(code_q));
  // R12
  code_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (code_q == '0));
endmodule

// File: rtl/ldst_port_monitor.sv
module ldst_port_monitor
  import ldst_mon_pkg::*;
#(
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort_i,
  input  logic          clr_err_i,
  input  logic          ld_req_i,
  input  logic          st_req_i,
  input  logic          busy_i,
  input  logic          addr_vld_i,
  input  logic [AW-1:0] addr_i,
  input  logic          addr_ack_i,
  input  logic          addr_exc_i,
  input  logic          ld_vld_i,
  input  logic          st_vld_i,
  output logic          err_o,
  output logic [3:0]    err_code_o,
  output logic          txn_done_o
);
  localparam int PULSE_N = 4;

  logic                track;
  logic                move;
  logic                wide;
  logic [RULE_N:1]     hits;
  logic [CODE_W-1:0]   code;

  ldst_mon_pulse #(.N(PULSE_N)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  ({addr_ack_i, addr_exc_i, ld_vld_i, st_vld_i}),
    .wide_o (wide)
  );

  ldst_mon_addr #(.AW(AW)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .track_i (track),
    .vld_i   (addr_vld_i),
    .addr_i  (addr_i),
    .move_o  (move)
  );

  ldst_mon_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort_i  (abort_i),
    .ld_req_i (ld_req_i),
    .st_req_i (st_req_i),
    .busy_i   (busy_i),
    .ack_i    (addr_ack_i),
    .exc_i    (addr_exc_i),
    .ld_vld_i (ld_vld_i),
    .st_vld_i (st_vld_i),
    .move_i   (move),
    .wide_i   (wide),
    .track_o  (track),
    .hit_o    (hits),
    .done_o   (txn_done_o)
  );

  ldst_mon_errlog u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_err_i),
    .hit_i  (hits),
    .code_o (code),
    .err_o  (err_o)
  );

  assign err_code_o = code;
endmodule

// File: tb/ldst_port_monitor_tb.sv
module ldst_port_monitor_tb_top;
  localparam int AW = 48;
  localparam logic [AW-1:0] ADR_A = 48'h1234;
  localparam logic [AW-1:0] ADR_B = 48'h1238;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic abort = 1'b0, clr = 1'b0;
  logic lr = 0, sr = 0, bz = 0, av = 0, ak = 0, ex = 0, lv = 0, sv = 0;
  logic [AW-1:0] ad = '0;
  logic err;
  logic [3:0] code;
  logic done;

  int n_run = 0, n_fail = 0, n_done = 0;
  bit finished = 0;
  string tag = "R1";

  // model state
  int m_ph = 0;  // 0 idle, 1 wait, 2 open, 3 sending
  bit m_load = 0, m_acked = 0, m_ans = 0, m_reqp = 0, m_lock = 0;
  bit m_akp = 0, m_exp = 0, m_lvp = 0, m_svp = 0;
  logic [AW-1:0] m_held = '0;
  int m_code = 0;

  always #10 clk = ~clk;

  ldst_port_monitor #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .abort_i(abort), .clr_err_i(clr),
    .ld_req_i(lr), .st_req_i(sr), .busy_i(bz), .addr_vld_i(av), .addr_i(ad),
    .addr_ack_i(ak), .addr_exc_i(ex), .ld_vld_i(lv), .st_vld_i(sv),
    .err_o(err), .err_code_o(code), .txn_done_o(done)
  );

  task automatic check(input string t, input string what, input int got, input int want);
    n_run++;
    if (got != want) begin
      n_fail++;
      $display("FAIL %s %s got %0d expected %0d", t, what, got, want);
    end
  endtask

  // one cycle: inputs already applied at the falling edge
  task automatic tick();
    int broken[$];
    int low;
    bit act, nreq, ldok, stok, exp_done, trk;
    int nph;
    #5;
    act  = (m_ph == 1) || (m_ph == 2);
    nreq = (lr || sr) && !m_reqp;
    ldok = act && m_load && m_acked;
    stok = act && !m_load && m_acked;
    if (!abort) begin
      if (lr && sr) broken.push_back(1);
      if (nreq && bz) broken.push_back(2);
      if (m_ph == 1 && !bz) broken.push_back(3);
      if (act && bz && m_lock && (!av || ad != m_held)) broken.push_back(4);
      if ((ak && m_akp) || (ex && m_exp) || (lv && m_lvp) || (sv && m_svp)) broken.push_back(5);
      if ((ak || ex) && (!act || m_ans)) broken.push_back(6);
      if (ex && bz && act) broken.push_back(7);
      if (lv && !ldok) broken.push_back(8);
      if (lv && bz && act) broken.push_back(9);
      if (sv && !stok) broken.push_back(10);
      if (m_ph == 3 && bz) broken.push_back(11);
      if (m_ph == 2 && !bz && !ex && !lv) broken.push_back(12);
    end
    exp_done = !abort && broken.size() == 0 &&
               ((m_ph == 2 && !bz && lv && ldok) || (m_ph == 3 && !bz));
    if (done) n_done++;
    check(tag, "txn_done", int'(done), int'(exp_done));
    check(tag, "err_code", int'(code), m_code);
    check(tag, "err_flag", int'(err), int'(m_code != 0));
    // error capture
    low = 99;
    foreach (broken[i]) if (broken[i] < low) low = broken[i];
    if (clr) m_code = 0;
    else if (m_code == 0 && low != 99) m_code = low;
    // address tracking
    trk = act && bz && !abort;
    if (trk && av && !m_lock) m_held = ad;
    m_lock = trk && (m_lock || av);
    // phase
    nph = m_ph;
    if (m_ph == 0) begin
      if (nreq && !(lr && sr)) begin
        nph = 1; m_load = lr; m_acked = 0; m_ans = 0;
      end
    end else if (act) begin
      if (!bz) nph = 0;
      else begin
        nph = (sv && stok) ? 3 : 2;
        m_acked = m_acked || ak;
        m_ans = m_ans || ak || ex;
      end
    end else nph = 0;
    if (abort) nph = 0;
    m_ph = nph;
    m_reqp = lr || sr; m_akp = ak; m_exp = ex; m_lvp = lv; m_svp = sv;
    @(negedge clk);
  endtask

  // bit order: {ld_req, st_req, busy, addr_vld, ack, exc, ld_vld, st_vld}
  task automatic drv(input logic [7:0] b, input logic [AW-1:0] a);
    {lr, sr, bz, av, ak, ex, lv, sv} = b;
    ad = a;
    tick();
  endtask

  task automatic do_abort();
    abort = 1; drv(8'b0000_0000, '0); abort = 0;
  endtask

  task automatic do_clr();
    clr = 1; drv(8'b0000_0000, '0); clr = 0;
  endtask

  task automatic chk_code(input string t, input int want);
    check(t, "held code", int'(code), want);
    check(t, "held flag", int'(err), int'(want != 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    check("R1", "reset code", int'(code), 0);
    check("R1", "reset flag", int'(err), 0);
    check("R1", "reset done", int'(done), 0);
    @(negedge clk);
    rst_n = 1;

    tag = "R13";  // correct load then correct store
    drv(8'b1001_0000, ADR_A); drv(8'b1011_0000, ADR_A); drv(8'b1011_1000, ADR_A);
    drv(8'b1011_0000, ADR_A); drv(8'b1001_0010, ADR_A); drv(8'b0000_0000, ADR_A);
    drv(8'b0101_0000, ADR_B); drv(8'b0111_0000, ADR_B); drv(8'b0111_1000, ADR_B);
    drv(8'b0111_0001, ADR_B); drv(8'b0101_0000, ADR_B); drv(8'b0000_0000, ADR_B);
    check("R13", "done pulses", n_done, 2);
    chk_code("R13", 0);

    tag = "R8";  // exception with busy falling together
    drv(8'b1001_0000, ADR_A); drv(8'b1011_0000, ADR_A); drv(8'b1001_0100, ADR_A);
    drv(8'b0000_0000, ADR_A);
    chk_code("R8", 0);
    check("R8", "no done on exception", n_done, 2);

    tag = "R2";
    drv(8'b1101_0000, ADR_A); drv(8'b0000_0000, ADR_A);
    chk_code("R2", 1); do_clr();

    tag = "R3";
    drv(8'b1001_0000, ADR_A); drv(8'b1011_0000, ADR_A); drv(8'b0011_0000, ADR_A);
    drv(8'b1011_0000, ADR_A);
    chk_code("R3", 2); do_abort(); do_clr();

    tag = "R4";
    drv(8'b1001_0000, ADR_A); drv(8'b1001_0000, ADR_A); drv(8'b0000_0000, ADR_A);
    chk_code("R4", 3); do_clr();

    tag = "R5";
    drv(8'b1001_0000, ADR_A); drv(8'b1011_0000, ADR_A); drv(8'b1011_0000, ADR_B);
    chk_code("R5", 4); do_abort(); do_clr();
    drv(8'b1001_0000, ADR_A); drv(8'b1011_0000, ADR_A); drv(8'b1010_0000, ADR_A);
    chk_code("R5", 4); do_abort(); do_clr();

    tag = "R6";
    drv(8'b1001_0000, ADR_A); drv(8'b1011_0000, ADR_A); drv(8'b1011_1000, ADR_A);
    drv(8'b1011_1000, ADR_A);
    chk_code("R6", 5); do_abort(); do_clr();

    tag = "R7";
    drv(8'b0000_1000, ADR_A); drv(8'b0000_0000, ADR_A);
    chk_code("R7", 6); do_clr();
    drv(8'b1001_0000, ADR_A); drv(8'b1011_0000, ADR_A); drv(8'b1011_1000, ADR_A);
    drv(8'b1001_0100, ADR_A); drv(8'b0000_0000, ADR_A);
    chk_code("R7", 6); do_clr();

    tag = "R1";
    abort = 1; drv(8'b1101_0000, ADR_A); abort = 0;
    drv(8'b0000_0000, ADR_A);
    chk_code("R1", 0);
    drv(8'b1001_0000, ADR_A); drv(8'b1011_0000, ADR_A); do_abort();
    drv(8'b0000_1000, ADR_A); drv(8'b0000_0000, ADR_A);
    chk_code("R1", 6); do_clr();

    tag = "R8";
    drv(8'b1001_0000, ADR_A); drv(8'b1011_0000, ADR_A); drv(8'b1011_0100, ADR_A);
    chk_code("R8", 7); do_abort(); do_clr();

    tag = "R9";
    drv(8'b1001_0000, ADR_A); drv(8'b1011_0000, ADR_A); drv(8'b1001_0010, ADR_A);
    drv(8'b0000_0000, ADR_A);
    chk_code("R9", 8); do_clr();
    drv(8'b1001_0000, ADR_A); drv(8'b1011_0000, ADR_A); drv(8'b1011_1000, ADR_A);
    drv(8'b1011_0010, ADR_A);
    chk_code("R9", 9); do_abort(); do_clr();

    tag = "R10";
    drv(8'b0101_0000, ADR_B); drv(8'b0111_0000, ADR_B); drv(8'b0111_0001, ADR_B);
    chk_code("R10", 10); do_abort(); do_clr();
    drv(8'b0101_0000, ADR_B); drv(8'b0111_0000, ADR_B); drv(8'b0111_1000, ADR_B);
    drv(8'b0111_0001, ADR_B); drv(8'b0111_0000, ADR_B); drv(8'b0000_0000, ADR_B);
    chk_code("R10", 11); do_clr();

    tag = "R11";
    drv(8'b1001_0000, ADR_A); drv(8'b1011_0000, ADR_A); drv(8'b1011_1000, ADR_A);
    drv(8'b1001_0000, ADR_A); drv(8'b0000_0000, ADR_A);
    chk_code("R11", 12);

    tag = "R12";  // held code survives a later violation
    drv(8'b1101_0000, ADR_A); drv(8'b0000_0000, ADR_A);
    chk_code("R12", 12); do_clr();
    drv(8'b1111_0000, ADR_A); drv(8'b0000_0000, ADR_A);
    chk_code("R12", 1); do_clr();
    clr = 1; drv(8'b0000_1000, ADR_A); clr = 0;
    drv(8'b0000_0000, ADR_A);
    chk_code("R12", 0);

    check("R13", "final done pulses", n_done, 2);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule